// File: doc/BRIEF.md
# Armable Debug Event Counter

This block counts debug events for a monitoring unit. Software sets a 32-bit count value and a 16-bit control word. The counter then decrements once for each occurrence of a chosen event source, and signals when it reaches zero. The event sources are six address-comparator detections, one data-comparator detection, and an external debug pin. The pin counts only while it is configured as an input.

A 4-bit enable field in the control word can do three things: hold the counter off, run it, or arm it on a trigger source. When an armed trigger fires, the hardware rewrites the enable field to the running code on the next clock edge. If the trigger and the counted event are the same source, that first occurrence is counted. If they differ, it is not counted.

The block has no streaming data path. All of its pins are plain control and status signals, so no valid/ready handshake and no back-pressure rules apply.

Top module: `dbgc_top`

## Requirements
- R1: After reset, the control word reads 0x0000, the count reads 0 and `term_pulse` is low. Control bits 15:9 always read zero. Bit 8 is an extended-mode flag that is only stored and read back.
- R2: Enable field code 0x0 (bits 7:4) holds the counter off. Code 0xF runs it, and each clock cycle in which the selected source is high decrements the count by one.
- R3: Enable codes 0x7, 0x8, 0xB, 0xC, 0xD and 0xE are reserved. With any of them, the count never changes and the field is never rewritten.
- R4: Codes 0x1 to 0x6 arm on address comparators 0 to 5, code 0x9 on the data comparator, and code 0xA on the debug pin. The first trigger makes the enable field read 0xF from the next clock edge onward.
- R5: While `dbg_pin_is_input` is low, the debug pin neither arms the counter (code 0xA) nor is counted (select 0xA).
- R6: When the arming source equals the select field, the triggering occurrence decrements the count.
- R7: When the arming source differs from the select field, the triggering occurrence is not counted. Later occurrences of the selected source are counted.
- R8: The select field (bits 3:0) uses the same numbering as the enable field: 1 to 6 for the address comparators, 9 for the data comparator, 10 for the pin. Any other value counts nothing.
- R9: The count holds at zero. `term_pulse` is high for exactly the one cycle that follows the edge at which the count steps from 1 to 0.
- R10: A software control write in the same cycle as an armed trigger wins: the enable field takes the written value.
- R11: With `reg_sel`=0, the port accesses the control word in bits 15:0. With `reg_sel`=1, it accesses the 32-bit count. A count write has priority over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | 0 = control word, 1 = count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| addr_cmp_hit | input | 6 | Address comparator detection pulses |
| data_cmp_hit | input | 1 | Data comparator detection pulse |
| dbg_pin | input | 1 | External debug pin level |
| dbg_pin_is_input | input | 1 | Pin direction, 1 = input |
| count_value | output | 32 | Current count |
| term_pulse | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
Register writes, count decrements and the hardware rewrite of the enable field all take effect at the first rising edge after the stimulus is applied. The terminal pulse comes from a register fed by the same edge, so it is high during the cycle that follows that edge and low one cycle later. The bench drives every stimulus at a falling edge and removes it at the next falling edge, then samples the outputs just after that second falling edge. Read data is combinational, so each sample sees the state left by exactly one rising edge. The terminal pulse is checked once at that point and once a full cycle later.

// File: rtl/dbgc_pkg.sv
`timescale 1ns/1ps
package dbgc_pkg;
  localparam int CTRL_W = 16;
  localparam logic [3:0] CODE_OFF  = 4'h0;
  localparam logic [3:0] CODE_RUN  = 4'hF;
  localparam logic [3:0] CODE_DATA = 4'h9;
  localparam logic [3:0] CODE_PIN  = 4'hA;

  // Codes that arm the counter on a trigger source
  function automatic logic is_arm_code(input logic [3:0] c);
    return ((c >= 4'h1) && (c <= 4'h6)) || (c == CODE_DATA) || (c == CODE_PIN);
  endfunction

  // Reserved enable codes
  function automatic logic is_rsvd_code(input logic [3:0] c);
    return (c == 4'h7) || (c == 4'h8) || ((c >= 4'hB) && (c <= 4'hE));
  endfunction
endpackage

// File: rtl/dbgc_src_mux.sv
`timescale 1ns/1ps
module dbgc_src_mux #(
  parameter int N_ADDR = 6
) (
  input  logic [3:0]        code,
  input  logic [N_ADDR-1:0] addr_hit,
  input  logic              data_hit,
  input  logic              pin_level,
  input  logic              pin_is_input,
  output logic              hit
);
  import dbgc_pkg::*;

  logic [N_ADDR-1:0] addr_match;

  generate
    for (genvar g = 0; g < N_ADDR; g++) begin : g_addr
      assign addr_match[g] = (code == 4'(g + 1)) && addr_hit[g];
    end
  endgenerate

  always_comb begin
    hit = |addr_match;
    if (code == CODE_DATA) hit = data_hit;
    if (code == CODE_PIN)  hit = pin_level && pin_is_input;
  end
endmodule

// File: rtl/dbgc_ctrl_reg.sv
`timescale 1ns/1ps
module dbgc_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [8:0] wdata,
  input  logic       trig_hit,
  output logic       ext_mode,
  output logic [3:0] en_field,
  output logic [3:0] sel_field,
  output logic       armed,
  output logic       running
);
  import dbgc_pkg::*;

  assign armed   = is_arm_code(en_field);
  assign running = (en_field == CODE_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mode  <= 1'b0;
      en_field  <= CODE_OFF;
      sel_field <= 4'h0;
    end else if (wr_en) begin
      ext_mode  <= wdata[8];
      en_field  <= wdata[7:4];
      sel_field <= wdata[3:0];
    end else if (armed && trig_hit) begin
      en_field  <= CODE_RUN;
    end
  end

  AST_ARM_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_hit && !wr_en) |=> (en_field == CODE_RUN)); // R4
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_field == $past(wdata[7:4]))); // R10
  AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rsvd_code(en_field) && !wr_en) |=> $stable(en_field)); // R3
endmodule

// File: rtl/dbgc_down_counter.sv
`timescale 1ns/1ps
module dbgc_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             term
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      term <= 1'b0;
    end else begin
      term <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (dec && !at_zero) begin
        cnt  <= cnt - ONE;
        term <= (cnt == ONE);
      end
    end
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !load) |=> (cnt == '0)); // R9
  AST_TERM_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> (cnt == '0)); // R9
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !at_zero) |=> (cnt == $past(cnt) - ONE)); // R2
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R11
endmodule

// File: rtl/dbgc_top.sv
`timescale 1ns/1ps
module dbgc_top #(
  parameter int N_ADDR = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_ADDR-1:0] addr_cmp_hit,
  input  logic              data_cmp_hit,
  input  logic              dbg_pin,
  input  logic              dbg_pin_is_input,
  output logic [CNT_W-1:0]  count_value,
  output logic              term_pulse
);
  import dbgc_pkg::*;

  logic       ext_mode, armed, running;
  logic [3:0] en_field, sel_field;
  logic       trig_hit, sel_hit, count_ev;
  logic       ctrl_wr, cnt_wr;

  assign ctrl_wr = reg_wr_en && !reg_sel;
  assign cnt_wr  = reg_wr_en && reg_sel;

  dbgc_src_mux #(.N_ADDR(N_ADDR)) u_trig_mux (
    .code(en_field), .addr_hit(addr_cmp_hit), .data_hit(data_cmp_hit),
    .pin_level(dbg_pin), .pin_is_input(dbg_pin_is_input), .hit(trig_hit));

  dbgc_src_mux #(.N_ADDR(N_ADDR)) u_sel_mux (
    .code(sel_field), .addr_hit(addr_cmp_hit), .data_hit(data_cmp_hit),
    .pin_level(dbg_pin), .pin_is_input(dbg_pin_is_input), .hit(sel_hit));

  dbgc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(reg_wdata[8:0]),
    .trig_hit(trig_hit), .ext_mode(ext_mode), .en_field(en_field),
    .sel_field(sel_field), .armed(armed), .running(running));

  // Same-source arming counts the triggering occurrence
  assign count_ev = sel_hit && (running || (armed && trig_hit && (en_field == sel_field)));

  dbgc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(CNT_W'(reg_wdata)),
    .dec(count_ev), .cnt(count_value), .term(term_pulse));

  always_comb begin
    if (reg_sel) reg_rdata = 32'(count_value);
    else         reg_rdata = {16'h0, 7'h0, ext_mode, en_field, sel_field};
  end

  AST_RSVD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    is_rsvd_code(en_field) |-> !count_ev); // R3
  AST_OFF_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_field == CODE_OFF) |-> !count_ev); // R2
  AST_PIN_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_pin_is_input && (en_field == CODE_PIN)) |-> !trig_hit); // R5
  AST_DIFF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (en_field != sel_field)) |-> !count_ev); // R7
endmodule

// File: tb/sim_dbgc_top.sv
`timescale 1ns/1ps
module sim_dbgc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  addr_cmp_hit = '0;
  logic        data_cmp_hit = 1'b0;
  logic        dbg_pin = 1'b0;
  logic        dbg_pin_is_input = 1'b1;
  logic [31:0] count_value;
  logic        term_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbgc_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_cmp_hit(addr_cmp_hit),
    .data_cmp_hit(data_cmp_hit), .dbg_pin(dbg_pin), .dbg_pin_is_input(dbg_pin_is_input),
    .count_value(count_value), .term_pulse(term_pulse));

  // {ctrl word, event bits {pin,data,addr5..0}, expected enable, expected count}
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {16'h00F1, 8'h01, 4'hF, 16'd99},   // R2 running, addr0 counted
    {16'h00F1, 8'h02, 4'hF, 16'd100},  // R8 other source ignored
    {16'h0001, 8'h01, 4'h0, 16'd100},  // R2 disabled
    {16'h0071, 8'h01, 4'h7, 16'd100},  // R3 reserved 7
    {16'h00E1, 8'h01, 4'hE, 16'd100},  // R3 reserved E
    {16'h0011, 8'h01, 4'hF, 16'd99},   // R6 same source arm
    {16'h0012, 8'h01, 4'hF, 16'd100},  // R7 different source arm
    {16'h0099, 8'h40, 4'hF, 16'd99},   // R6 data comparator
    {16'h00AA, 8'h80, 4'hF, 16'd99},   // R4 pin arm as input
    {16'h00F9, 8'h40, 4'hF, 16'd99},   // R8 data select
    {16'h00F7, 8'hFF, 4'hF, 16'd100},  // R8 select 7 counts nothing
    {16'h00F6, 8'h20, 4'hF, 16'd99},   // R8 addr5 select
    {16'h00FA, 8'h80, 4'hF, 16'd99},   // R8 pin select
    {16'h0066, 8'h20, 4'hF, 16'd99}    // R4 arm on addr5
  };
  string vtag [NV] = '{"R2","R8","R2","R3","R3","R6","R7","R6","R4","R8","R8","R8","R8","R4"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk);
    addr_cmp_hit = ev[5:0]; data_cmp_hit = ev[6]; dbg_pin = ev[7];
    @(negedge clk);
    addr_cmp_hit = '0; data_cmp_hit = 1'b0; dbg_pin = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic prep(input logic [31:0] cnt, input logic [15:0] ctrl);
    wr(1'b0, 32'h0);
    wr(1'b1, cnt);
    wr(1'b0, {16'h0, ctrl});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, v); check("R1 ctrl reset", v, 32'h0);
    rd(1'b1, v); check("R1 count reset", v, 32'h0);
    check("R1 term reset", 32'(term_pulse), 32'h0);

    for (int i = 0; i < NV; i++) begin
      prep(32'd100, VEC[i][43:28]);
      pulse(VEC[i][27:20]);
      rd(1'b0, v); check({vtag[i], " enable"}, 32'(v[7:4]), 32'(VEC[i][19:16]));
      rd(1'b1, v); check({vtag[i], " count"}, v, 32'(VEC[i][15:0]));
    end

    // R1 reserved bits read zero, extended flag stored
    wr(1'b0, 32'h0000FFFF);
    rd(1'b0, v); check("R1 reserved zero", v, 32'h01FF);

    // R5 pin as output never arms
    dbg_pin_is_input = 1'b0;
    prep(32'd100, 16'h00AA);
    pulse(8'h80);
    rd(1'b0, v); check("R5 enable stays", 32'(v[7:4]), 32'hA);
    rd(1'b1, v); check("R5 count kept", v, 32'd100);
    // R5 pin as output not counted while running
    prep(32'd100, 16'h00FA);
    pulse(8'h80);
    rd(1'b1, v); check("R5 run count kept", v, 32'd100);
    dbg_pin_is_input = 1'b1;

    // R7 later occurrences of selected source counted
    prep(32'd100, 16'h0012);
    pulse(8'h01);
    rd(1'b1, v); check("R7 trigger not counted", v, 32'd100);
    pulse(8'h02);
    rd(1'b1, v); check("R7 later counted", v, 32'd99);

    // R9 reach zero, pulse once, hold
    prep(32'd2, 16'h00F1);
    pulse(8'h01);
    check("R9 no early term", 32'(term_pulse), 32'h0);
    pulse(8'h01);
    rd(1'b1, v); check("R9 count zero", v, 32'h0);
    check("R9 term high", 32'(term_pulse), 32'h1);
    @(negedge clk);
    check("R9 term one cycle", 32'(term_pulse), 32'h0);
    pulse(8'h01);
    rd(1'b1, v); check("R9 hold zero", v, 32'h0);
    check("R9 no second term", 32'(term_pulse), 32'h0);

    // R10 software write beats hardware rewrite
    prep(32'd100, 16'h0011);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0031; addr_cmp_hit = 6'h01;
    @(negedge clk);
    reg_wr_en = 1'b0; addr_cmp_hit = '0;
    rd(1'b0, v); check("R10 sw wins", 32'(v[7:4]), 32'h3);

    // R11 count write beats decrement
    prep(32'd50, 16'h00F1);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 32'd7; addr_cmp_hit = 6'h01;
    @(negedge clk);
    reg_wr_en = 1'b0; addr_cmp_hit = '0;
    rd(1'b1, v); check("R11 load priority", v, 32'd7);
    check("R11 count port", count_value, 32'd7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule